// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a processor load/store port and a slower word-addressed memory. Each byte address is cut into three fields: the low `OFF_W` bits pick a byte inside a word, the next `IDX_W` bits pick one set, and the remaining high bits form the tag. Each set holds one word, one tag and one valid flag. A read whose set is valid and whose stored tag matches is answered from the cache. A read that misses fetches the word from memory, installs it in its set, and then answers.

Every store goes to memory. If the store address is already cached, the cached word is also updated. A store that misses leaves the cache untouched. Only one transaction is in flight at a time. With the default parameters there are 256 sets. Setting `IDX_W` to 14 gives a 16-bit tag over 16,384 sets.

Requests use valid/ready: a request is taken on a clock edge where both `req_valid` and `req_ready` are high, and `req_ready` is high only while the block is idle. Responses also use valid/ready: `rsp_valid` and `rsp_rdata` hold steady until `rsp_ready` is seen. No new request is taken while a response waits. On the memory side, `mem_req` and its address, data and direction are held until a one-cycle `mem_ack`. For reads, that acknowledge also carries `mem_rdata`.

Top module: `dmc_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0. All valid flags are cleared, so the first read of any set misses.
- R2: The set is `req_addr[OFF_W+IDX_W-1:OFF_W]` and the tag is `req_addr[ADDR_W-1:OFF_W+IDX_W]`. The offset bits `req_addr[OFF_W-1:0]` play no part in lookup, so two reads of different bytes in the same word hit the same entry.
- R3: A read that hits raises `rsp_valid` on the cycle after acceptance with `rsp_hit` = 1 and the cached word. It issues no memory request.
- R4: A read that misses raises `mem_req` with `mem_we` = 0 and `mem_addr` = `req_addr >> OFF_W` on the cycle after acceptance. The cycle after `mem_ack`, `rsp_valid` rises with `rsp_hit` = 0 and the data returned by memory.
- R5: A miss fill replaces whatever entry held that set. With byte addresses 0x0, 0x2, 0x34, 0x400, 0x0 on 256 sets of 4-byte lines, the results are miss, hit, miss, miss, miss, because 0x400 maps to set 0 and evicts the entry holding 0x0.
- R6: Every accepted store raises `mem_req` with `mem_we` = 1, the word address and `req_wdata` on the cycle after acceptance. Stores produce no response, and `req_ready` returns the cycle after `mem_ack`.
- R7: A store that hits also updates the cached word, so a later read hits and returns the stored value.
- R8: A store that misses does not allocate: a later read of that address misses, and the entry already in that set is still valid.
- R9: `req_ready` is 0 from acceptance until the block returns to idle. While `rsp_valid` is 1 and `rsp_ready` is 0, the response stays valid with unchanged data.
- R10: While `mem_req` is 1 and `mem_ack` is 0, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data (whole word) |
| rsp_valid | output | 1 | Load response valid |
| rsp_ready | input | 1 | Processor takes the response |
| rsp_hit | output | 1 | 1 when the response came from the cache |
| rsp_rdata | output | DATA_W | Load data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W-OFF_W | Word address to memory |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | One-cycle completion from memory |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |

## Verification
The bench drives a request at a falling edge, and the request is taken at the next rising edge. At the first falling edge after that, a hit must already show `rsp_valid`, while a miss or a store must instead show `mem_req` with the right direction, address and data. The memory model acknowledges a fixed latency after it first sees `mem_req`. A miss answer is expected exactly one cycle after that acknowledge, and for a store `req_ready` must return at that same point. The bench counts falling edges to require exactly that position. The expected hit or miss and the expected data come from a behavioural model of sets, tags and memory contents that the bench keeps up to date with every transaction.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_STORE = 2'd2,
    ST_RESP  = 2'd3
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_array.sv
module dmc_tag_array #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] look_idx,
  input  logic [TAG_W-1:0] look_tag,
  output logic             look_hit,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag
);
  localparam int SETS = 1 << IDX_W;

  logic [TAG_W-1:0] tags [SETS];
  logic [SETS-1:0]  vld;

  // valid flags reset; tags only meaningful when valid
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (fill_en) begin
      vld[fill_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tags[fill_idx] <= fill_tag;
    end
  end

  assign look_hit = vld[look_idx] && (tags[look_idx] == look_tag);
endmodule

// File: rtl/dmc_data_array.sv
module dmc_data_array #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int SETS = 1 << IDX_W;

  logic [DATA_W-1:0] words [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      words[wr_idx] <= wr_data;
    end
  end

  assign rd_data = words[rd_idx];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int WADDR_W = 30,
  parameter int IDX_W   = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [WADDR_W-1:0] req_word,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               req_ready,
  input  logic               look_hit,
  input  logic [DATA_W-1:0]  look_data,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_hit,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic               mem_ack,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               fill_en,
  output logic [IDX_W-1:0]   fill_idx,
  output logic [WADDR_W-IDX_W-1:0] fill_tag,
  output logic               dwr_en,
  output logic [IDX_W-1:0]   dwr_idx,
  output logic [DATA_W-1:0]  dwr_data
);
  dmc_state_e         state_q, state_d;
  logic [WADDR_W-1:0] word_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               hit_q;
  logic               accept;
  logic               fill_now;

  assign accept   = req_valid && (state_q == ST_IDLE);
  assign fill_now = (state_q == ST_FETCH) && mem_ack;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (req_write)     state_d = ST_STORE;
          else if (look_hit) state_d = ST_RESP;
          else               state_d = ST_FETCH;
        end
      end
      ST_FETCH: if (mem_ack)   state_d = ST_RESP;
      ST_STORE: if (mem_ack)   state_d = ST_IDLE;
      ST_RESP:  if (rsp_ready) state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      word_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      hit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        word_q  <= req_word;
        wdata_q <= req_wdata;
        if (!req_write && look_hit) begin
          rdata_q <= look_data;
          hit_q   <= 1'b1;
        end
      end
      if (fill_now) begin
        rdata_q <= mem_rdata;
        hit_q   <= 1'b0;
      end
    end
  end

  // array write ports: miss fill has priority slot in FETCH, store hit in IDLE
  assign fill_en  = fill_now;
  assign fill_idx = word_q[IDX_W-1:0];
  assign fill_tag = word_q[WADDR_W-1:IDX_W];

  always_comb begin
    if (fill_now) begin
      dwr_en   = 1'b1;
      dwr_idx  = word_q[IDX_W-1:0];
      dwr_data = mem_rdata;
    end else begin
      dwr_en   = accept && req_write && look_hit;
      dwr_idx  = req_word[IDX_W-1:0];
      dwr_data = req_wdata;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_hit   = hit_q;
  assign rsp_rdata = rdata_q;
  assign mem_req   = (state_q == ST_FETCH) || (state_q == ST_STORE);
  assign mem_we    = (state_q == ST_STORE);
  assign mem_addr  = word_q;
  assign mem_wdata = wdata_q;
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int OFF_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic                    rsp_hit,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-OFF_W-1:0] mem_addr,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic                    mem_ack,
  input  logic [DATA_W-1:0]       mem_rdata
);
  localparam int WADDR_W = ADDR_W - OFF_W;
  localparam int TAG_W   = WADDR_W - IDX_W;

  logic [WADDR_W-1:0] req_word;
  logic [IDX_W-1:0]   look_idx;
  logic [TAG_W-1:0]   look_tag;
  logic               look_hit;
  logic [DATA_W-1:0]  look_data;
  logic               fill_en;
  logic [IDX_W-1:0]   fill_idx;
  logic [TAG_W-1:0]   fill_tag;
  logic               dwr_en;
  logic [IDX_W-1:0]   dwr_idx;
  logic [DATA_W-1:0]  dwr_data;

  // byte offset dropped: whole-word accesses only
  assign req_word = req_addr[ADDR_W-1:OFF_W];
  assign look_idx = req_word[IDX_W-1:0];
  assign look_tag = req_word[WADDR_W-1:IDX_W];

  dmc_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .look_idx (look_idx),
    .look_tag (look_tag),
    .look_hit (look_hit),
    .fill_en  (fill_en),
    .fill_idx (fill_idx),
    .fill_tag (fill_tag)
  );

  dmc_data_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rd_idx  (look_idx),
    .rd_data (look_data),
    .wr_en   (dwr_en),
    .wr_idx  (dwr_idx),
    .wr_data (dwr_data)
  );

  dmc_ctrl #(.WADDR_W(WADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_word  (req_word),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .look_hit  (look_hit),
    .look_data (look_data),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_hit   (rsp_hit),
    .rsp_rdata (rsp_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .fill_en   (fill_en),
    .fill_idx  (fill_idx),
    .fill_tag  (fill_tag),
    .dwr_en    (dwr_en),
    .dwr_idx   (dwr_idx),
    .dwr_data  (dwr_data)
  );
endmodule

// File: rtl/dmc_cache_chk.sv
module dmc_cache_chk #(
  parameter int WADDR_W = 30,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic               rsp_hit,
  input logic [DATA_W-1:0]  rsp_rdata,
  input logic               mem_req,
  input logic               mem_we,
  input logic [WADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0]  mem_wdata,
  input logic               mem_ack
);
  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> !mem_req); // R3

  AST_FILL_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (rsp_valid && !rsp_hit)); // R4

  AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> (mem_req && mem_we)); // R6

  AST_STORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (req_ready && !rsp_valid)); // R6

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || rsp_valid) |-> !req_ready); // R9

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_hit))); // R9

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata))); // R10
endmodule

bind dmc_cache dmc_cache_chk #(.WADDR_W(ADDR_W - OFF_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_hit   (rsp_hit),
  .rsp_rdata (rsp_rdata),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack)
);

// File: tb/tb_dmc_cache.sv
module tb_dmc_cache;
  localparam int ADDR_W = 32, IDX_W = 8, OFF_W = 2, DATA_W = 32, LAT = 3;
  localparam int SETS = 1 << IDX_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 0, mem_ack = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0, mem_rdata = '0;
  logic req_ready, rsp_valid, rsp_hit, mem_req, mem_we;
  logic [DATA_W-1:0] rsp_rdata, mem_wdata;
  logic [ADDR_W-OFF_W-1:0] mem_addr;

  dmc_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  always #2 clk = ~clk;

  int n_vec = 0, n_bad = 0, cyc = 0, mcnt = 0;
  logic [DATA_W-1:0] mem_m [int];
  bit mval [int];
  int mtag [int];

  function automatic logic [DATA_W-1:0] get_mem(int w);
    if (mem_m.exists(w)) return mem_m[w];
    return (w * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model: fixed latency from first sight of mem_req
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      mcnt++;
      if (mcnt == LAT) begin
        mcnt = 0;
        mem_ack = 1;
        if (mem_we) mem_m[int'(mem_addr)] = mem_wdata;
        else mem_rdata = get_mem(int'(mem_addr));
      end
    end
  end

  always @(posedge clk) cyc++;

  initial begin
    wait (cyc >= 100000);
    chk(0, "WD", "watchdog expired", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  task automatic read_op(input logic [ADDR_W-1:0] a, output bit hit_o);
    int w = int'(a >> OFF_W);
    int idx = w % SETS;
    int tg = w / SETS;
    bit exp_hit = mval.exists(idx) && mval[idx] && (mtag[idx] == tg);
    logic [DATA_W-1:0] exp_d = get_mem(w);
    int k;
    @(negedge clk);
    chk(req_ready == 1, "R9", "ready before read", req_ready, 1);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    if (exp_hit) begin
      chk(rsp_valid == 1, "R3", "hit response next cycle", rsp_valid, 1);
      chk(mem_req == 0, "R3", "hit makes no mem request", mem_req, 0);
    end else begin
      chk(mem_req && !mem_we, "R4", "miss fetch request", {mem_req, mem_we}, 2'b10);
      chk(mem_addr == w, "R4", "fetch word address", mem_addr, w);
      chk(req_ready == 0, "R9", "not ready during fetch", req_ready, 0);
      k = 1;
      while (!rsp_valid && k < 50) begin @(negedge clk); k++; end
      chk(k == LAT + 1, "R4", "miss response cycle", k, LAT + 1);
      mval[idx] = 1; mtag[idx] = tg;
    end
    chk(rsp_hit == exp_hit, exp_hit ? "R3" : "R5", "hit flag", rsp_hit, exp_hit);
    chk(rsp_rdata == exp_d, exp_hit ? "R3" : "R4", "read data", rsp_rdata, exp_d);
    hit_o = rsp_hit;
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk(!rsp_valid && req_ready, "R9", "idle after response", {rsp_valid, req_ready}, 2'b01);
  endtask

  task automatic write_op(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    int w = int'(a >> OFF_W);
    int k;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    chk(mem_req && mem_we, "R6", "store request", {mem_req, mem_we}, 2'b11);
    chk(mem_addr == w, "R6", "store word address", mem_addr, w);
    chk(mem_wdata == d, "R6", "store data", mem_wdata, d);
    chk(!rsp_valid && !req_ready, "R9", "busy during store", {rsp_valid, req_ready}, 0);
    k = 1;
    while (mem_req && k < 50) begin @(negedge clk); k++; end
    chk(k == LAT + 1 && req_ready, "R6", "store completion cycle", k, LAT + 1);
    chk(!rsp_valid, "R6", "no response to store", rsp_valid, 0);
    chk(get_mem(w) == d, "R6", "memory updated", get_mem(w), d);
  endtask

  initial begin
    bit h;
    bit seq[5];
    logic [ADDR_W-1:0] trace[5] = '{32'h0, 32'h2, 32'h34, 32'h400, 32'h0};
    logic [DATA_W-1:0] held;
    int unsigned lcg = 32'h1234_5678;
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0 && mem_req == 0, "R1", "outputs in reset",
        {req_ready, rsp_valid, mem_req}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0 && mem_req == 0, "R1", "idle after reset",
        {req_ready, rsp_valid, mem_req}, 3'b100);

    // R5 thrash trace (also R1 first miss, R2 offset-insensitive hit)
    for (int i = 0; i < 5; i++) begin read_op(trace[i], h); seq[i] = h; end
    chk(seq[0] == 0, "R1", "first read misses", seq[0], 0);
    chk(seq[1] == 1, "R2", "other byte same word hits", seq[1], 1);
    chk({seq[2], seq[3], seq[4]} == 3'b000, "R5", "eviction pattern",
        {seq[2], seq[3], seq[4]}, 0);

    read_op(32'h34, h);
    chk(h == 1, "R3", "repeat read hits", h, 1);

    // R7 store hit updates cache
    write_op(32'h34, 32'hCAFE_0134);
    read_op(32'h36, h);
    chk(h == 1, "R7", "read after store hit", h, 1);

    // R8 store miss does not allocate
    write_op(32'h800, 32'hBEEF_0800);
    read_op(32'h0, h);
    chk(h == 1, "R8", "resident entry kept", h, 1);
    read_op(32'h800, h);
    chk(h == 0, "R8", "store miss not allocated", h, 0);

    // R9 back-pressure on a hit response
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 32'h800;
    @(negedge clk);
    req_valid = 0;
    held = rsp_rdata;
    chk(rsp_valid && rsp_hit, "R3", "bp hit", {rsp_valid, rsp_hit}, 2'b11);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == held && !req_ready, "R9", "response held",
          rsp_rdata, held);
    end
    chk(held == 32'hBEEF_0800, "R9", "held data", held, 32'hBEEF_0800);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk(!rsp_valid && req_ready, "R9", "released", {rsp_valid, req_ready}, 2'b01);

    // mixed traffic over a small conflicting pool
    for (int i = 0; i < 60; i++) begin
      logic [ADDR_W-1:0] a;
      lcg = lcg * 1103515245 + 12345;
      a = ((lcg >> 8) % 4) << (IDX_W + OFF_W) | ((lcg >> 12) % 6) << OFF_W | ((lcg >> 16) % 4);
      if (((lcg >> 20) % 4) == 0) write_op(a, lcg ^ 32'h0F0F_1234);
      else read_op(a, h);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule